// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block is the host side of a parallel printer port on a small I/O bus. The bus carries a 10-bit port address and a flag that marks the access as I/O rather than memory. It also carries separate read and write strobes, an 8-bit write bus and an 8-bit read bus. The block answers at three consecutive port addresses that start at a base address (0x378 by default). Offset 0 is a data latch, offset 1 is a status port and offset 2 is a control port. Every other address is left alone.

On the printer side the block drives eight data lines and a strobe line. It samples a ready input, which is high when the printer can take a new byte. The ready input passes through a two-flop synchroniser before software can see it.

To send one byte, software reads the status port until bit 7 is 1. It then writes the byte to the data port, writes 0x01 to the control port and then writes 0x00 there. The strobe is high for exactly the time between those two control writes. The hardware enforces no pulse widths.

Top module: `prn_port_ctrl`

## Requirements
- R1: A write or read takes effect only when `io_sel` is 1 and `io_addr` is BASE, BASE+1 or BASE+2. A memory access (`io_sel` = 0) to those addresses leaves every register unchanged. Such a read returns 0.
- R2: A write to BASE loads `io_wdata` into the data latch at the next rising clock edge. `prn_data` then shows that byte. With no such write, `prn_data` holds its value.
- R3: A read of BASE+1 returns the ready input in bit 7, after a two-flop synchroniser. A change on `prn_ready` appears in a read after the second rising edge. Bits 6 to 0 read 0.
- R4: A write to BASE+2 stores the whole byte in the control register. `prn_strobe` follows control bit 0 from the next edge. It stays unchanged until the next control write, even when the data port is written.
- R5: A read of BASE returns the last byte latched into the data port.
- R6: A read of BASE+2 returns the full stored control byte.
- R7: An active-low reset clears the data latch and the control register. `prn_data` then reads 0x00 and `prn_strobe` is low.
- R8: An access to any other address changes no register and no printer output. `io_rdata` is 0 whenever no read of one of the three decoded ports is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 10 | Port address |
| io_sel | input | 1 | 1 = I/O space access, 0 = memory access |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe (write is taken at the rising edge) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational, 0 when not reading a decoded port) |
| prn_data | output | 8 | Printer data lines |
| prn_strobe | output | 1 | Printer strobe line |
| prn_ready | input | 1 | Printer can accept a byte (asynchronous) |

## Verification
On every cycle the checker confirms four things. A data or control write reaches `prn_data` or `prn_strobe` one edge later. Both outputs hold whenever no matching write occurs. The read bus is zero outside a decoded read. The status bit equals the ready input from two edges earlier. Two behaviours can only be shown by the bench's scenarios. One is that a byte can be written and later read back through the same port. The other is that rejected memory accesses and neighbouring addresses leave the state alone, as seen through later reads. The bench also steps through the ordered send sequence: poll, data write, strobe raise, strobe clear.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;

   typedef enum logic [1:0] {
      PSEL_NONE = 2'd0,
      PSEL_DATA = 2'd1,
      PSEL_STAT = 2'd2,
      PSEL_CTRL = 2'd3
   } port_sel_e;

   localparam int unsigned PORT_COUNT = 3;

endpackage

// File: rtl/prn_addr_decode.sv
module prn_addr_decode
   import prn_port_pkg::*;
#(
   parameter int unsigned ADDR_W    = 10,
   parameter int unsigned BASE_ADDR = 10'h378
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_sel,
   output port_sel_e         port_sel
);

   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);

   logic [ADDR_W-1:0] offset;

   always_comb begin
      offset   = io_addr - BASE_V;
      port_sel = PSEL_NONE;
      if (io_sel) begin
         unique case (offset)
            ADDR_W'(0): port_sel = PSEL_DATA;
            ADDR_W'(1): port_sel = PSEL_STAT;
            ADDR_W'(2): port_sel = PSEL_CTRL;
            default:    port_sel = PSEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/prn_sync.sv
module prn_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= d_async;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/prn_port_regs.sv
module prn_port_regs
   import prn_port_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_wr,
   input  port_sel_e         port_sel,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] ctrl_q
);

   logic data_we;
   logic ctrl_we;

   assign data_we = io_wr && (port_sel == PSEL_DATA);
   assign ctrl_we = io_wr && (port_sel == PSEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (data_we) data_q <= io_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_we) ctrl_q <= io_wdata;
   end

endmodule

// File: rtl/prn_rd_mux.sv
module prn_rd_mux
   import prn_port_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned READY_BIT = 7,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_rd,
   input  port_sel_e         port_sel,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] ctrl_q,
   input  logic              ready_sync,
   output logic [DATA_W-1:0] io_rdata
);

   logic [DATA_W-1:0] status_w;
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      status_w            = '0;
      status_w[READY_BIT] = ready_sync;
   end

   always_comb begin
      rd_next = '0;
      if (io_rd) begin
         unique case (port_sel)
            PSEL_DATA: rd_next = data_q;
            PSEL_STAT: rd_next = status_w;
            PSEL_CTRL: rd_next = ctrl_q;
            default:   rd_next = '0;
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_next;
      end
      assign io_rdata = rd_q;
   end else begin : g_rd_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign io_rdata   = rd_next;
   end

endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
   import prn_port_pkg::*;
#(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BASE_ADDR   = 10'h378,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned READY_BIT   = 7,
   parameter int unsigned STROBE_BIT  = 0,
   parameter bit          RDATA_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_sel,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic [DATA_W-1:0] prn_data,
   output logic              prn_strobe,
   input  logic              prn_ready
);

   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;
   localparam longint unsigned LAST_PORT = BASE_ADDR + PORT_COUNT - 1;

   if (LAST_PORT >= ADDR_SPAN) begin : g_bad_base
      $error("port window runs past the top of the address space");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ready synchroniser needs at least two stages");
   end
   if (READY_BIT >= DATA_W || STROBE_BIT >= DATA_W) begin : g_bad_bit
      $error("status or strobe bit outside the data width");
   end

   port_sel_e         port_sel;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] ctrl_q;
   logic              ready_sync;

   prn_addr_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR)
   ) u_dec (
      .io_addr  (io_addr),
      .io_sel   (io_sel),
      .port_sel (port_sel)
   );

   prn_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (prn_ready),
      .q_sync  (ready_sync)
   );

   prn_port_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_wr    (io_wr),
      .port_sel (port_sel),
      .io_wdata (io_wdata),
      .data_q   (data_q),
      .ctrl_q   (ctrl_q)
   );

   prn_rd_mux #(
      .DATA_W    (DATA_W),
      .READY_BIT (READY_BIT),
      .RDATA_REG (RDATA_REG)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_rd      (io_rd),
      .port_sel   (port_sel),
      .data_q     (data_q),
      .ctrl_q     (ctrl_q),
      .ready_sync (ready_sync),
      .io_rdata   (io_rdata)
   );

   assign prn_data   = data_q;
   assign prn_strobe = ctrl_q[STROBE_BIT];

endmodule

// File: rtl/prn_port_chk.sv
module prn_port_chk #(
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned BASE_ADDR   = 10'h378,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned READY_BIT   = 7,
   parameter int unsigned STROBE_BIT  = 0,
   parameter bit          RDATA_REG   = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_sel,
   input logic              io_rd,
   input logic              io_wr,
   input logic [DATA_W-1:0] io_wdata,
   input logic [DATA_W-1:0] io_rdata,
   input logic [DATA_W-1:0] prn_data,
   input logic              prn_strobe,
   input logic              prn_ready
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_ADDR + 1);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + 2);

   logic data_wr, ctrl_wr, dec_rd, stat_rd;
   assign data_wr = io_sel && io_wr && (io_addr == A_DATA);
   assign ctrl_wr = io_sel && io_wr && (io_addr == A_CTRL);
   assign stat_rd = io_sel && io_rd && (io_addr == A_STAT);
   assign dec_rd  = io_sel && io_rd &&
                    ((io_addr == A_DATA) || (io_addr == A_STAT) || (io_addr == A_CTRL));

   logic [1:0] edges_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              edges_q <= '0;
      else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
   end

   // R7
   p_reset_clear_r7: assert property (@(posedge clk)
      !rst_n |=> (prn_data == '0 && !prn_strobe));

   // R2
   p_data_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> prn_data == $past(io_wdata));
   p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !data_wr |=> $stable(prn_data));

   // R4
   p_strobe_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> prn_strobe == $past(io_wdata[STROBE_BIT]));
   p_strobe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(prn_strobe));

   if (!RDATA_REG) begin : g_rd_props
      // R8
      p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !dec_rd |-> io_rdata == '0);
      // R3
      p_status_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
         stat_rd |-> $countones(io_rdata) <= 1 && io_rdata[READY_BIT] == |io_rdata);
      if (SYNC_STAGES == 2) begin : g_sync2
         p_status_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_rd && edges_q == 2'd2) |-> io_rdata[READY_BIT] == $past(prn_ready, 2));
      end
   end

endmodule

bind prn_port_ctrl prn_port_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BASE_ADDR   (BASE_ADDR),
   .SYNC_STAGES (SYNC_STAGES),
   .READY_BIT   (READY_BIT),
   .STROBE_BIT  (STROBE_BIT),
   .RDATA_REG   (RDATA_REG)
) u_chk (.*);

// File: tb/sim_prn_port_ctrl.sv
module sim_prn_port_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] io_addr = '0;
   logic       io_sel = 1'b0;
   logic       io_rd = 1'b0;
   logic       io_wr = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [7:0] prn_data;
   logic       prn_strobe;
   logic       prn_ready = 1'b1;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   prn_port_ctrl u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .io_sel     (io_sel),
      .io_rd      (io_rd),
      .io_wr      (io_wr),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .prn_data   (prn_data),
      .prn_strobe (prn_strobe),
      .prn_ready  (prn_ready)
   );

   // {rd, wr, sel, addr[10], wdata[8], exp_rdata[8], exp_pdata[8], exp_strobe, req[4]}
   localparam int NV = 17;
   localparam logic [41:0] VEC [NV] = '{
      {1'b0,1'b1,1'b1,10'h378,8'hA5,8'h00,8'hA5,1'b0,4'd2}, // R2 data write
      {1'b1,1'b0,1'b1,10'h378,8'h00,8'hA5,8'hA5,1'b0,4'd5}, // R5 data readback
      {1'b1,1'b0,1'b1,10'h379,8'h00,8'h80,8'hA5,1'b0,4'd3}, // R3 ready poll
      {1'b0,1'b1,1'b1,10'h37A,8'h01,8'h00,8'hA5,1'b1,4'd4}, // R4 strobe up
      {1'b0,1'b1,1'b1,10'h378,8'h3C,8'h00,8'h3C,1'b1,4'd4}, // R4 strobe held over data write
      {1'b0,1'b1,1'b1,10'h37B,8'hFF,8'h00,8'h3C,1'b1,4'd8}, // R8 neighbour write
      {1'b1,1'b0,1'b1,10'h37B,8'h00,8'h00,8'h3C,1'b1,4'd8}, // R8 neighbour read
      {1'b0,1'b1,1'b0,10'h378,8'h11,8'h00,8'h3C,1'b1,4'd1}, // R1 memory write
      {1'b1,1'b0,1'b0,10'h37A,8'h00,8'h00,8'h3C,1'b1,4'd1}, // R1 memory read
      {1'b1,1'b0,1'b1,10'h37A,8'h00,8'h01,8'h3C,1'b1,4'd6}, // R6 control read
      {1'b0,1'b1,1'b1,10'h37A,8'h00,8'h00,8'h3C,1'b0,4'd4}, // R4 strobe down
      {1'b0,1'b1,1'b1,10'h37A,8'hFE,8'h00,8'h3C,1'b0,4'd4}, // R4 bit 0 only drives strobe
      {1'b1,1'b0,1'b1,10'h37A,8'h00,8'hFE,8'h3C,1'b0,4'd6}, // R6 full byte kept
      {1'b0,1'b1,1'b1,10'h178,8'h77,8'h00,8'h3C,1'b0,4'd1}, // R1 upper bits differ
      {1'b1,1'b0,1'b1,10'h377,8'h00,8'h00,8'h3C,1'b0,4'd8}, // R8 below window
      {1'b1,1'b0,1'b1,10'h378,8'h00,8'h3C,8'h3C,1'b0,4'd5}, // R5 latest byte
      {1'b0,1'b0,1'b1,10'h378,8'h00,8'h00,8'h3C,1'b0,4'd8}  // R8 no strobe, bus idle
   };

   task automatic check8(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic go_idle();
      io_rd = 1'b0; io_wr = 1'b0; io_sel = 1'b0; io_addr = '0; io_wdata = '0;
   endtask

   task automatic access(input logic rd, input logic wr, input logic [9:0] a,
                         input logic [7:0] d, output logic [7:0] rv);
      @(negedge clk);
      io_sel = 1'b1; io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
      #1 rv = io_rdata;
      @(negedge clk);
      go_idle();
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      logic [7:0] rv;
      // R7 reset state
      repeat (3) @(negedge clk);
      check8("R7", "prn_data in reset", prn_data, 8'h00);
      check8("R7", "strobe in reset", {7'b0, prn_strobe}, 8'h00);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      access(1'b1, 1'b0, 10'h37A, 8'h00, rv);
      check8("R7", "control after reset", rv, 8'h00);
      access(1'b1, 1'b0, 10'h378, 8'h00, rv);
      check8("R7", "data after reset", rv, 8'h00);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [41:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d", v[3:0]);
         @(negedge clk);
         io_rd = v[41]; io_wr = v[40]; io_sel = v[39];
         io_addr = v[38:29]; io_wdata = v[28:21];
         #1 check8(tag, $sformatf("vec %0d rdata", i), io_rdata, v[20:13]);
         @(negedge clk);
         go_idle();
         check8(tag, $sformatf("vec %0d prn_data", i), prn_data, v[12:5]);
         check8(tag, $sformatf("vec %0d strobe", i), {7'b0, prn_strobe}, {7'b0, v[4]});
      end

      // R3 synchroniser latency: fall
      @(negedge clk);
      prn_ready = 1'b0;
      io_sel = 1'b1; io_rd = 1'b1; io_addr = 10'h379;
      @(negedge clk);
      check8("R3", "status one edge after fall", io_rdata, 8'h80);
      @(negedge clk);
      check8("R3", "status two edges after fall", io_rdata, 8'h00);
      // rise
      prn_ready = 1'b1;
      @(negedge clk);
      check8("R3", "status one edge after rise", io_rdata, 8'h00);
      @(negedge clk);
      check8("R3", "status two edges after rise", io_rdata, 8'h80);
      go_idle();

      // full send sequence R4: strobe spans exactly the two control writes
      access(1'b1, 1'b0, 10'h379, 8'h00, rv);
      check8("R3", "poll before send", rv, 8'h80);
      access(1'b0, 1'b1, 10'h378, 8'h5A, rv);
      check8("R2", "send byte on lines", prn_data, 8'h5A);
      access(1'b0, 1'b1, 10'h37A, 8'h01, rv);
      check8("R4", "strobe after raise", {7'b0, prn_strobe}, 8'h01);
      repeat (4) @(negedge clk);
      check8("R4", "strobe held while idle", {7'b0, prn_strobe}, 8'h01);
      access(1'b0, 1'b1, 10'h37A, 8'h00, rv);
      check8("R4", "strobe after clear", {7'b0, prn_strobe}, 8'h00);

      // R7 reset mid-run
      access(1'b0, 1'b1, 10'h37A, 8'h81, rv);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check8("R7", "data cleared by reset", prn_data, 8'h00);
      check8("R7", "strobe cleared by reset", {7'b0, prn_strobe}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      access(1'b1, 1'b0, 10'h37A, 8'h00, rv);
      check8("R7", "control read after reset", rv, 8'h00);

      summary();
   end

endmodule